// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns a pair of conditioned quadrature phase signals into a signed-direction position count. Each clock it compares the current levels of phase A and phase B with the levels seen one clock earlier. From a legal single-phase transition it derives a count step and its direction. A 32-bit register accumulates the steps.

Two resolutions are offered. In x4 mode every edge of either phase counts. In x2 mode only edges of A count, and the level of B sets their sense. Each resolution can run with one of two wrap policies. Free-counting wraps across the full 32-bit range. Compare-counting wraps between zero and a programmable maximum, which fits one encoder revolution.

The counter can be zeroed by a rising index input and overwritten through a software write port. It raises single-cycle pulses on wraparound, on a reversal of counting direction, and on reaching a programmable compare value. Flag storage, interrupt logic and input filtering are expected to sit around this block.

Top module: `qenc_position_counter`

## Requirements
- R1: After reset, `count` is 0, `dir_up` is 0 (down) and all three event pulses are 0.
- R2: With `mode` 00 (x4 free) or 10 (x4 compare), every clock in which exactly one phase has changed since the previous clock moves the count by one. The walk {A,B} 00→10→11→01→00 (A leads B) counts up, and the reverse walk counts down.
- R3: With `mode` 01 (x2 free) or 11 (x2 compare), only a change of A with B unchanged counts. A rising A while B is 0, or a falling A while B is 1, counts up; the other two cases count down. A change of B alone leaves the count unchanged.
- R4: In the free modes (`mode[1]`=0), an up step from 0xFFFFFFFF gives 0 and a down step from 0 gives 0xFFFFFFFF. Each such wrap raises `wrap_pulse`.
- R5: In the compare modes (`mode[1]`=1), an up step from `max_value` gives 0 and a down step from 0 gives `max_value`. Each such wrap raises `wrap_pulse`. Steps that do not wrap leave `wrap_pulse` at 0.
- R6: `dir_up` takes the direction of each counted step. `dir_change_pulse` is raised when that direction differs from the previous value of `dir_up`.
- R7: While `cmp_enable` is 1, a counted step whose result equals `cmp_value` raises `cmp_match_pulse`. While `cmp_enable` is 0, no match pulse is raised.
- R8: When `enable` and `index_reload_en` are both 1, a rising edge on `index_in` loads 0 into the count. When `index_reload_en` is 0, the index input has no effect on the count.
- R9: While `enable` is 0, phase changes do not alter the count. Phase history keeps tracking, so re-enabling produces no spurious step.
- R10: A `sw_wr` cycle loads `sw_data` into the count on the next edge. It takes priority over a simultaneous phase step or index reload.
- R11: A clock in which both phases changed since the previous clock is treated as illegal. It leaves the count, the direction and all pulses unchanged.
- R12: The pulses are registered alongside the count update, so they are visible in the same cycle as the new count, and each lasts one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Counting enable |
| mode | input | 2 | bit0: x2 resolution, bit1: compare-limited wrap |
| cmp_enable | input | 1 | Compare function enable |
| index_reload_en | input | 1 | Enables index-driven reload to zero |
| phase_a | input | 1 | Conditioned phase A |
| phase_b | input | 1 | Conditioned phase B |
| index_in | input | 1 | Conditioned index signal |
| max_value | input | 32 | Wrap limit in compare modes |
| cmp_value | input | 32 | Compare target |
| sw_wr | input | 1 | Software count write strobe |
| sw_data | input | 32 | Software count write data |
| count | output | 32 | Position count |
| dir_up | output | 1 | 1 = counting up, 0 = counting down |
| wrap_pulse | output | 1 | One-cycle overflow/underflow event |
| dir_change_pulse | output | 1 | One-cycle direction reversal event |
| cmp_match_pulse | output | 1 | One-cycle compare-match event |

## Verification
The bound checker watches, on every cycle, the relations that can be stated at the ports. These are: holding while disabled, the write-port load, the landing value after each kind of wrap, that a direction pulse coincides with a flip of `dir_up`, that a match pulse lands on the compare value, and that illegal double-phase changes and lone B changes in x2 mode leave the count untouched. The directed scenarios add what needs a known history: the exact up/down sense of each quadrature transition, the count values along a walk, the absence of a match pulse with compare disabled, index reload being ignored when disabled, and the pulses clearing one cycle after they fire.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  // mode[0] selects x2 resolution, mode[1] selects compare-limited wrap
  localparam int MODE_X2_BIT  = 0;
  localparam int MODE_CMP_BIT = 1;

  typedef struct packed {
    logic valid;
    logic up;
  } step_t;

  // Decode one clock of phase history into a count step.
  // Up sense follows the A-leads-B walk 00 -> 10 -> 11 -> 01 -> 00 on {A,B}.
  function automatic step_t decode_step(input logic pa, input logic pb,
                                        input logic a, input logic b,
                                        input logic x2);
    step_t s;
    logic a_chg, b_chg;
    a_chg = (a != pa);
    b_chg = (b != pb);
    s.valid = 1'b0;
    s.up    = 1'b0;
    if (a_chg && !b_chg) begin
      s.valid = 1'b1;
      s.up    = (a != b);
    end else if (b_chg && !a_chg && !x2) begin
      s.valid = 1'b1;
      s.up    = (b == a);
    end
    return s;
  endfunction

endpackage

// File: rtl/qenc_edge_decode.sv
module qenc_edge_decode
  import qenc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic x2_mode,
  input  logic phase_a,
  input  logic phase_b,
  input  logic index_in,
  output logic step_valid,
  output logic step_up,
  output logic index_rise
);

  logic  prev_a, prev_b, prev_idx;
  step_t step;

  // History follows the inputs even in reset and while disabled, so that
  // leaving either state never sees a stale edge.
  always_ff @(posedge clk) begin
    prev_a   <= phase_a;
    prev_b   <= phase_b;
    prev_idx <= rst_n ? index_in : 1'b1;
  end

  always_comb begin
    step       = decode_step(prev_a, prev_b, phase_a, phase_b, x2_mode);
    step_valid = rst_n && enable && step.valid;
    step_up    = step.up;
    index_rise = rst_n && index_in && !prev_idx;
  end

endmodule

// File: rtl/qenc_count_core.sv
module qenc_count_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_valid,
  input  logic             step_up,
  input  logic             cmp_mode,
  input  logic [CNT_W-1:0] max_value,
  input  logic             index_load,
  input  logic             sw_wr,
  input  logic [CNT_W-1:0] sw_data,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] nxt_count,
  output logic             step_applied,
  output logic             wrap_pulse
);

  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ZERO     = '0;

  // Returns {wrap, value} for one step inside [0, limit].
  function automatic logic [CNT_W:0] advance(input logic [CNT_W-1:0] cur,
                                             input logic up,
                                             input logic [CNT_W-1:0] limit);
    logic [CNT_W:0] r;
    if (up) begin
      if (cur == limit) r = {1'b1, ZERO};
      else              r = {1'b0, cur + 1'b1};
    end else begin
      if (cur == ZERO)  r = {1'b1, limit};
      else              r = {1'b0, cur - 1'b1};
    end
    return r;
  endfunction

  logic [CNT_W-1:0] limit;
  logic [CNT_W:0]   adv;
  logic             nxt_wrap;

  always_comb begin
    limit        = cmp_mode ? max_value : ALL_ONES;
    adv          = advance(count, step_up, limit);
    step_applied = step_valid && !sw_wr && !index_load;
    nxt_wrap     = 1'b0;
    if (sw_wr) begin
      nxt_count = sw_data;
    end else if (index_load) begin
      nxt_count = ZERO;
    end else if (step_valid) begin
      nxt_count = adv[CNT_W-1:0];
      nxt_wrap  = adv[CNT_W];
    end else begin
      nxt_count = count;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count      <= ZERO;
      wrap_pulse <= 1'b0;
    end else begin
      count      <= nxt_count;
      wrap_pulse <= nxt_wrap;
    end
  end

endmodule

// File: rtl/qenc_dir_track.sv
module qenc_dir_track (
  input  logic clk,
  input  logic rst_n,
  input  logic step_applied,
  input  logic step_up,
  output logic dir_up,
  output logic dir_change_pulse
);

  logic reversal;

  always_comb reversal = step_applied && (step_up != dir_up);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_up           <= 1'b0;
      dir_change_pulse <= 1'b0;
    end else begin
      if (step_applied) dir_up <= step_up;
      dir_change_pulse <= reversal;
    end
  end

endmodule

// File: rtl/qenc_compare.sv
module qenc_compare #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_enable,
  input  logic             step_applied,
  input  logic [CNT_W-1:0] nxt_count,
  input  logic [CNT_W-1:0] cmp_value,
  output logic             cmp_match_pulse
);

  logic hit;

  always_comb hit = cmp_enable && step_applied && (nxt_count == cmp_value);

  always_ff @(posedge clk) begin
    if (!rst_n) cmp_match_pulse <= 1'b0;
    else        cmp_match_pulse <= hit;
  end

endmodule

// File: rtl/qenc_position_counter.sv
module qenc_position_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       mode,
  input  logic             cmp_enable,
  input  logic             index_reload_en,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic             index_in,
  input  logic [CNT_W-1:0] max_value,
  input  logic [CNT_W-1:0] cmp_value,
  input  logic             sw_wr,
  input  logic [CNT_W-1:0] sw_data,
  output logic [CNT_W-1:0] count,
  output logic             dir_up,
  output logic             wrap_pulse,
  output logic             dir_change_pulse,
  output logic             cmp_match_pulse
);

  // Internal events, named so that checks can refer to them
  logic             step_valid;
  logic             step_up;
  logic             index_rise;
  logic             index_load;
  logic             step_applied;
  logic [CNT_W-1:0] nxt_count;

  qenc_edge_decode u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .x2_mode    (mode[MODE_X2_BIT]),
    .phase_a    (phase_a),
    .phase_b    (phase_b),
    .index_in   (index_in),
    .step_valid (step_valid),
    .step_up    (step_up),
    .index_rise (index_rise)
  );

  always_comb index_load = enable && index_reload_en && index_rise;

  qenc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_valid   (step_valid),
    .step_up      (step_up),
    .cmp_mode     (mode[MODE_CMP_BIT]),
    .max_value    (max_value),
    .index_load   (index_load),
    .sw_wr        (sw_wr),
    .sw_data      (sw_data),
    .count        (count),
    .nxt_count    (nxt_count),
    .step_applied (step_applied),
    .wrap_pulse   (wrap_pulse)
  );

  qenc_dir_track u_dir (
    .clk              (clk),
    .rst_n            (rst_n),
    .step_applied     (step_applied),
    .step_up          (step_up),
    .dir_up           (dir_up),
    .dir_change_pulse (dir_change_pulse)
  );

  qenc_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk             (clk),
    .rst_n           (rst_n),
    .cmp_enable      (cmp_enable),
    .step_applied    (step_applied),
    .nxt_count       (nxt_count),
    .cmp_value       (cmp_value),
    .cmp_match_pulse (cmp_match_pulse)
  );

endmodule

// File: rtl/qenc_checker.sv
module qenc_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [1:0]       mode,
  input logic             cmp_enable,
  input logic             index_reload_en,
  input logic             phase_a,
  input logic             phase_b,
  input logic             index_in,
  input logic [CNT_W-1:0] max_value,
  input logic [CNT_W-1:0] cmp_value,
  input logic             sw_wr,
  input logic [CNT_W-1:0] sw_data,
  input logic [CNT_W-1:0] count,
  input logic             dir_up,
  input logic             wrap_pulse,
  input logic             dir_change_pulse,
  input logic             cmp_match_pulse
);

  p_hold_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !sw_wr) |=> $stable(count));

  p_sw_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> (count == $past(sw_data)));

  p_wrap_up_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_pulse && dir_up) |-> (count == '0));

  p_wrap_down_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_pulse && !dir_up && !$past(mode[1])) |-> (count == {CNT_W{1'b1}}));

  p_wrap_down_cmp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_pulse && !dir_up && $past(mode[1])) |-> (count == $past(max_value)));

  p_dir_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dir_change_pulse |-> (dir_up != $past(dir_up)));

  p_cmp_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_match_pulse |-> ((count == $past(cmp_value)) && $past(cmp_enable)));

  p_illegal_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_a != $past(phase_a)) && (phase_b != $past(phase_b)) && !sw_wr &&
     !(index_reload_en && index_in && !$past(index_in)))
    |=> ($stable(count) && !wrap_pulse && !dir_change_pulse && !cmp_match_pulse));

  p_x2_b_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[0] && (phase_a == $past(phase_a)) && !sw_wr &&
     !(index_reload_en && index_in && !$past(index_in)))
    |=> $stable(count));

endmodule

bind qenc_position_counter qenc_checker #(.CNT_W(CNT_W)) u_qenc_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .enable           (enable),
  .mode             (mode),
  .cmp_enable       (cmp_enable),
  .index_reload_en  (index_reload_en),
  .phase_a          (phase_a),
  .phase_b          (phase_b),
  .index_in         (index_in),
  .max_value        (max_value),
  .cmp_value        (cmp_value),
  .sw_wr            (sw_wr),
  .sw_data          (sw_data),
  .count            (count),
  .dir_up           (dir_up),
  .wrap_pulse       (wrap_pulse),
  .dir_change_pulse (dir_change_pulse),
  .cmp_match_pulse  (cmp_match_pulse)
);

// File: tb/tb_qenc_position_counter.sv
module tb_qenc_position_counter;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic [1:0]  mode;
  logic        cmp_enable;
  logic        index_reload_en;
  logic        phase_a, phase_b, index_in;
  logic [31:0] max_value, cmp_value, sw_data;
  logic        sw_wr;
  logic [31:0] count;
  logic        dir_up, wrap_pulse, dir_change_pulse, cmp_match_pulse;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  qenc_position_counter dut (
    .clk (clk), .rst_n (rst_n), .enable (enable), .mode (mode),
    .cmp_enable (cmp_enable), .index_reload_en (index_reload_en),
    .phase_a (phase_a), .phase_b (phase_b), .index_in (index_in),
    .max_value (max_value), .cmp_value (cmp_value),
    .sw_wr (sw_wr), .sw_data (sw_data),
    .count (count), .dir_up (dir_up), .wrap_pulse (wrap_pulse),
    .dir_change_pulse (dir_change_pulse), .cmp_match_pulse (cmp_match_pulse)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic phase(input logic a, input logic b);
    phase_a = a;
    phase_b = b;
    tick();
  endtask

  task automatic sw_load(input logic [31:0] v);
    sw_wr = 1'b1; sw_data = v;
    tick();
    sw_wr = 1'b0;
  endtask

  task automatic pulses(input string req, input logic w, input logic d, input logic c);
    check(req, "wrap_pulse", 32'(wrap_pulse), 32'(w));
    check(req, "dir_change_pulse", 32'(dir_change_pulse), 32'(d));
    check(req, "cmp_match_pulse", 32'(cmp_match_pulse), 32'(c));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; enable = 1'b0; mode = 2'b00; cmp_enable = 1'b0;
    index_reload_en = 1'b0; phase_a = 1'b0; phase_b = 1'b0; index_in = 1'b0;
    max_value = '0; cmp_value = '0; sw_wr = 1'b0; sw_data = '0;
    repeat (4) tick();
    rst_n = 1'b1;
    tick();
    check("R1", "count", count, 32'd0);
    check("R1", "dir_up", 32'(dir_up), 32'd0);
    pulses("R1", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_x4();
    enable = 1'b1; mode = 2'b00;
    phase(1, 0); check("R2", "x4 up 1", count, 32'd1);
    check("R6", "dir_up", 32'(dir_up), 32'd1);
    pulses("R6", 1'b0, 1'b1, 1'b0);
    tick(); pulses("R12", 1'b0, 1'b0, 1'b0);
    phase(1, 1); check("R2", "x4 up 2", count, 32'd2);
    check("R6", "no reversal", 32'(dir_change_pulse), 32'd0);
    phase(0, 1); check("R2", "x4 up 3", count, 32'd3);
    phase(0, 0); check("R2", "x4 up 4", count, 32'd4);
    phase(0, 1); check("R2", "x4 down 3", count, 32'd3);
    check("R6", "dir_up down", 32'(dir_up), 32'd0);
    check("R6", "reversal", 32'(dir_change_pulse), 32'd1);
    phase(1, 1); check("R2", "x4 down 2", count, 32'd2);
  endtask

  task automatic t_illegal();
    phase(0, 0);
    check("R11", "count", count, 32'd2);
    check("R11", "dir_up", 32'(dir_up), 32'd0);
    pulses("R11", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_x2();
    mode = 2'b01;
    phase(0, 1); check("R3", "B rise ignored", count, 32'd2);
    phase(1, 1); check("R3", "A rise B high down", count, 32'd1);
    phase(0, 1); check("R3", "A fall B high up", count, 32'd2);
    phase(0, 0); check("R3", "B fall ignored", count, 32'd2);
  endtask

  task automatic t_free_wrap();
    mode = 2'b00;
    sw_load(32'd0);
    phase(0, 1); check("R4", "underflow", count, 32'hFFFF_FFFF);
    check("R4", "underflow pulse", 32'(wrap_pulse), 32'd1);
    phase(0, 0); check("R4", "overflow", count, 32'd0);
    check("R4", "overflow pulse", 32'(wrap_pulse), 32'd1);
    tick(); check("R12", "wrap clears", 32'(wrap_pulse), 32'd0);
  endtask

  task automatic t_cmp_wrap();
    mode = 2'b10; max_value = 32'd5;
    sw_load(32'd5);
    phase(1, 0); check("R5", "up past max", count, 32'd0);
    check("R5", "pulse up", 32'(wrap_pulse), 32'd1);
    phase(0, 0); check("R5", "down past zero", count, 32'd5);
    check("R5", "pulse down", 32'(wrap_pulse), 32'd1);
    phase(0, 1); check("R5", "interior", count, 32'd4);
    check("R5", "no pulse", 32'(wrap_pulse), 32'd0);
  endtask

  task automatic t_compare();
    mode = 2'b00; cmp_enable = 1'b1; cmp_value = 32'd10;
    sw_load(32'd9);
    check("R7", "no match on write", 32'(cmp_match_pulse), 32'd0);
    phase(0, 0); check("R7", "count", count, 32'd10);
    check("R7", "match", 32'(cmp_match_pulse), 32'd1);
    phase(1, 0); check("R7", "past target", 32'(cmp_match_pulse), 32'd0);
    cmp_enable = 1'b0;
    phase(0, 0); check("R7", "count back", count, 32'd10);
    check("R7", "disabled compare", 32'(cmp_match_pulse), 32'd0);
  endtask

  task automatic t_index();
    index_reload_en = 1'b1;
    sw_load(32'd7);
    index_in = 1'b1; tick();
    check("R8", "reload to zero", count, 32'd0);
    index_in = 1'b0;
    phase(1, 0); check("R8", "step after reload", count, 32'd1);
    index_reload_en = 1'b0;
    index_in = 1'b1; tick();
    check("R8", "reload disabled", count, 32'd1);
    index_in = 1'b0; tick();
  endtask

  task automatic t_enable();
    enable = 1'b0;
    phase(1, 1); check("R9", "held", count, 32'd1);
    enable = 1'b1; tick();
    check("R9", "no spurious step", count, 32'd1);
    phase(0, 1); check("R9", "counts again", count, 32'd2);
  endtask

  task automatic t_priority();
    sw_wr = 1'b1; sw_data = 32'd100;
    phase(0, 0);
    sw_wr = 1'b0;
    check("R10", "write wins over step", count, 32'd100);
    check("R10", "no wrap", 32'(wrap_pulse), 32'd0);
  endtask

  initial begin
    t_reset();
    t_x4();
    t_illegal();
    t_x2();
    t_free_wrap();
    t_cmp_wrap();
    t_compare();
    t_index();
    t_enable();
    t_priority();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule